// File: doc/BRIEF.md
# USB Host Interrupt Status and Enable Registers

This block holds the interrupt register group of a USB host controller. Eight hardware event pulses latch into a status register. Software reads the status over a simple register bus and clears bits by writing ones to them. An enable mask decides which latched events may raise the single interrupt line. Bit 31 of that mask is a master gate over all of them.

The mask has no plain write address. Software sets mask bits by writing ones at one address and clears them by writing ones at a second address. Both addresses read back the current mask. Software can therefore change one enable without a read-modify-write.

All registers live on a single clock with an active-low asynchronous reset. Reads are combinational from the address. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `usb_irq_regs`

## Requirements
- R1: After reset, the status register and the enable mask read as zero, and `irq_o` is low.
- R2: A high `hw_evt[k]` sets status bit k for k = 0..6, and a high `hw_evt[7]` sets status bit 30. Each set bit is visible from the cycle after the pulse and holds until software clears it.
- R3: A write at offset 0x0C clears every status bit whose data bit is 1. Status bits whose data bit is 0 are left unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write at offset 0x10 sets every implemented enable bit (31, 30, 6..0) whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R6: A write at offset 0x14 clears every enable bit whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R7: Reads at 0x10 and at 0x14 both return the current enable mask.
- R8: Status bits 31 and 29..7 always read as zero. Enable bits 29..7 always read as zero.
- R9: `irq_o` is high exactly when enable bit 31 is set and at least one of bits 30 and 6..0 is set in both the status and the enable mask. It follows the registers with no extra delay.
- R10: A read at any other offset returns zero. A write at any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_evt | input | 8 | Event pulses; bits 6..0 map to status 6..0, bit 7 to status 30 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at the same-cycle collision of an event and a clear. A design that lets the clear win would silently lose an event and would leave status bit 0 at zero.

It writes all ones to each register to expose reserved bits that stick. It writes all zeros to the status register to catch a plain write instead of write-one-to-clear.

It turns the master enable off and back on while a status bit is still pending. This catches a master bit that gates nothing, or one that also wipes the mask.

Writes at an unmapped offset and reads through the clear address catch an address decode that aliases the set, clear and status registers.

// File: rtl/usb_irq_regs.sv
module usb_irq_regs #(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] STS_OFF = 8'h0C,
  parameter logic [ADDR_W-1:0] ENA_OFF = 8'h10,
  parameter logic [ADDR_W-1:0] DIS_OFF = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        hw_evt,
  output logic              irq_o
);

  localparam logic [31:0] STS_MASK = 32'h4000_007F;
  localparam logic [31:0] ENA_MASK = 32'hC000_007F;

  logic [31:0] sts, ena, ev_bits;
  logic        wr_sts, wr_ena, wr_dis;

  assign ev_bits = {1'b0, hw_evt[7], 23'd0, hw_evt[6:0]};
  assign wr_sts  = bus_wr && (bus_addr == STS_OFF);
  assign wr_ena  = bus_wr && (bus_addr == ENA_OFF);
  assign wr_dis  = bus_wr && (bus_addr == DIS_OFF);

  // events are ORed in after the clear, so an event in the same cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= ((sts & ~(wr_sts ? bus_wdata : 32'd0)) | ev_bits) & STS_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena <= '0;
    else if (wr_ena) ena <= ena | (bus_wdata & ENA_MASK);
    else if (wr_dis) ena <= ena & ~bus_wdata;
  end

  always_comb begin
    unique case (bus_addr)
      STS_OFF:          bus_rdata = sts;
      ENA_OFF, DIS_OFF: bus_rdata = ena;
      default:          bus_rdata = '0;
    endcase
  end

  assign irq_o = ena[31] && |(sts & ena & STS_MASK);

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_evt) |=> ((sts & $past(ev_bits)) == $past(ev_bits)));

  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts |=> ((sts & $past(bus_wdata & ~ev_bits)) == 32'd0));

  // R5
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> ((ena & $past(bus_wdata & ENA_MASK)) == $past(bus_wdata & ENA_MASK)));

  // R6
  ena_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((ena & $past(bus_wdata)) == 32'd0));

  // R10
  ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ena || wr_dis) |=> $stable(ena));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~STS_MASK) == 32'd0) && ((ena & ~ENA_MASK) == 32'd0));

  // R9
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ena[31] |-> !irq_o);

endmodule

// File: tb/usb_irq_regs_tb.sv
module usb_irq_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  hw_evt = '0;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  usb_irq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt), .irq_o(irq_o)
  );

  // op: 0 write, 1 read+check, 2 event pulse (data[7:0])
  localparam int NV = 26;
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 8'h10, 32'h8000_0041, 32'h0},
    {2'd1, 8'h10, 32'h0, 32'h8000_0041},            // R5
    {2'd1, 8'h14, 32'h0, 32'h8000_0041},            // R7
    {2'd0, 8'h10, 32'hFFFF_FFFF, 32'h0},
    {2'd1, 8'h10, 32'h0, 32'hC000_007F},            // R8
    {2'd0, 8'h14, 32'h4000_003E, 32'h0},
    {2'd1, 8'h14, 32'h0, 32'h8000_0041},            // R6
    {2'd2, 8'h00, 32'h81, 32'h0},
    {2'd1, 8'h0C, 32'h0, 32'h4000_0001},            // R2
    {2'd0, 8'h0C, 32'h0, 32'h0},
    {2'd1, 8'h0C, 32'h0, 32'h4000_0001},            // R3 zeros
    {2'd0, 8'h0C, 32'h4000_0000, 32'h0},
    {2'd1, 8'h0C, 32'h0, 32'h0000_0001},            // R3
    {2'd0, 8'h0C, 32'hFFFF_FFFF, 32'h0},
    {2'd1, 8'h0C, 32'h0, 32'h0},                    // R3
    {2'd2, 8'h00, 32'h7F, 32'h0},
    {2'd1, 8'h0C, 32'h0, 32'h0000_007F},            // R2
    {2'd2, 8'h00, 32'h80, 32'h0},
    {2'd1, 8'h0C, 32'h0, 32'h4000_007F},            // R8
    {2'd0, 8'h0C, 32'hFFFF_FFFF, 32'h0},
    {2'd1, 8'h0C, 32'h0, 32'h0},
    {2'd0, 8'h20, 32'hFFFF_FFFF, 32'h0},
    {2'd1, 8'h20, 32'h0, 32'h0},                    // R10
    {2'd1, 8'h10, 32'h0, 32'h8000_0041},            // R10
    {2'd0, 8'h18, 32'hFFFF_FFFF, 32'h0},
    {2'd1, 8'h14, 32'h0, 32'h8000_0041}             // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic evt(input logic [7:0] e);
    @(negedge clk); hw_evt = e;
    @(negedge clk); hw_evt = '0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1 status", 8'h0C, 32'h0);
    rd("R1 enable", 8'h10, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][73:72])
        2'd0: wr(VEC[i][71:64], VEC[i][63:32]);
        2'd1: rd($sformatf("vector %0d (R2/R3/R5-R8/R10)", i), VEC[i][71:64], VEC[i][31:0]);
        default: evt(VEC[i][39:32]);
      endcase
    end

    // R9 interrupt behaviour, mask now 0x80000041
    evt(8'h02);
    @(negedge clk); check("R9 unmasked bit", {31'd0, irq_o}, 32'd0);
    evt(8'h01);
    @(negedge clk); check("R9 masked bit", {31'd0, irq_o}, 32'd1);
    wr(8'h14, 32'h8000_0000);
    check("R9 master off", {31'd0, irq_o}, 32'd0);
    rd("R9 mask after master off", 8'h10, 32'h0000_0041);
    wr(8'h10, 32'h8000_0000);
    check("R9 master on", {31'd0, irq_o}, 32'd1);
    wr(8'h14, 32'h0000_0001);
    check("R9 bit disabled", {31'd0, irq_o}, 32'd0);
    wr(8'h10, 32'h4000_0000);
    evt(8'h80);
    check("R9 bit30", {31'd0, irq_o}, 32'd1);
    wr(8'h0C, 32'hFFFF_FFFF);
    check("R9 cleared", {31'd0, irq_o}, 32'd0);

    // R4 collision: clear and event same cycle on bit 0; bit 1 cleared alone
    evt(8'h03);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h3; hw_evt = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0; hw_evt = '0;
    rd("R4 event wins", 8'h0C, 32'h1);

    // R1 reset mid-run
    wr(8'h10, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd("R1 status after reset", 8'h0C, 32'h0);
    rd("R1 disable addr after reset", 8'h14, 32'h0);
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule